// File: doc/BRIEF.md
# Reference Clock Qualifier with Holdover

This block runs entirely on a local oscillator clock (nominally 18.432 MHz) and watches a slow reference input (nominally 8 kHz, so one reference period is about 2304 local cycles). It measures the reference against the local clock over a window of 2^WIN_LOG2 reference periods and compares the cycle count with the nominal count. A window whose error lies within a ppm tolerance is in range. In-range windows steer a digital frequency-control word meant for a digitally tuned local oscillator. While the block is locked it drives the `safe` status high.

When the reference stops or drifts out of range, `safe` drops and the control word freezes at its last tracked value. The local oscillator therefore keeps its last good frequency, and the local clock is never switched or interrupted. When the reference returns, the block requalifies it with no external command and then resumes tracking. The control word only ever moves by one bounded, saturating step per window, so no transition between tracking and holdover produces a jump.

The default window of 4096 reference periods lasts about 0.51 s. Qualification from a valid reference to `safe` high therefore takes a few windows, which is well inside a 7 s budget.

Top module: `ref_clock_qualifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the acquire state with `safe` low and `ctrl_word` at mid-scale (only the MSB set, 128 for an 8-bit word).
- R2: A window spans exactly 2^WIN_LOG2 reference periods, counted between rising edges, and windows follow each other back to back. The error is the local cycle count of the window minus NOM_CYCLES·2^WIN_LOG2. A window is in range when |error| ≤ floor(NOM_CYCLES·2^WIN_LOG2·PPM_LIMIT/10^6), including the exact tolerance value on either side.
- R3: In the acquire state, every completed window changes `ctrl_word` by −(error >>> GAIN_SHIFT). The first in-range window moves the block to tracking, and `safe` goes high.
- R4: While tracking, each in-range window changes `ctrl_word` by −(error >>> GAIN_SHIFT) and `safe` stays high.
- R5: An out-of-range window while tracking drops `safe` and leaves `ctrl_word` unchanged.
- R6: If no rising reference edge arrives for LOSS_CYCLES local cycles, the reference is declared lost. `safe` goes low, `ctrl_word` freezes and the window in progress is discarded.
- R7: After holdover, `ctrl_word` stays frozen until two consecutive in-range windows have been seen. An out-of-range window restarts that count, and `safe` rises only at the end of the second window.
- R8: `ctrl_word` saturates at 0 and at 2^CTRL_W−1 and never wraps.
- R9: Only rising edges of the synchronised reference count; the high time of the reference has no effect on the measurement.
- R10: The first rising edge after a loss starts a new window, even in the cycle where the loss flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference clock input |
| safe | output | 1 | High while the reference is qualified and tracked |
| ctrl_word | output | CTRL_W | Frequency-control word for the local oscillator |

## Verification
The two functions that can fall in the same cycle are loss detection and the re-arming of the window meter. The first rising edge after a long gap reaches the meter while the loss flag is still set, and the meter has to start a new window rather than stay idle. The bench provokes this by holding the reference low well past the loss limit and then resuming with exact periods. It judges the result from `safe` and `ctrl_word` at the ends of the following windows. `safe` must rise exactly at the end of the second window, and the third window must steer the word by its exact error; a meter that lost the arming edge would shift every window by one period.

// File: rtl/rcq_pkg.sv
// Package: shared types for the reference clock qualifier.
// Assumes: nothing beyond IEEE 1800-2017.
package rcq_pkg;

    // Qualifier states; encoding carries no external meaning.
    typedef enum logic [1:0] {
        ST_ACQUIRE   = 2'd0,
        ST_TRACK     = 2'd1,
        ST_HOLDOVER  = 2'd2,
        ST_REQUALIFY = 2'd3
    } rcq_state_e;

endpackage

// File: rtl/rcq_edge_sync.sv
// Module: rcq_edge_sync
// Brings the asynchronous reference into the local clock domain through a
// STAGES-deep flop chain and emits a one-cycle pulse per rising transition.
// Assumes: STAGES >= 2; the reference stays high and low for several local cycles.
module rcq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchroniser chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ref_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // Rising transition of the synchronised reference.
    always_comb rise_pulse = chain_q[STAGES-1] & ~prev_q;

    // A pulse never lasts two cycles.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/rcq_loss_det.sv
// Module: rcq_loss_det
// Counts local cycles since the last reference rising edge and flags the
// reference as lost once the gap reaches LOSS_CYCLES.
// Assumes: rise_pulse is a single-cycle pulse from rcq_edge_sync.
module rcq_loss_det #(
    parameter int LOSS_CYCLES = 4608
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_pulse,
    output logic lost
);

    localparam int GW = $clog2(LOSS_CYCLES + 1);
    localparam logic [GW-1:0] LIMIT = GW'(LOSS_CYCLES);

    logic [GW-1:0] gap_q;

    // Gap counter: cleared by each edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (rise_pulse) begin
            gap_q <= '0;
        end else if (gap_q != LIMIT) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Loss flag follows the saturated counter.
    always_comb lost = (gap_q == LIMIT);

    // The cycle after an edge can never report a loss.
    p_no_loss_after_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !lost);

endmodule

// File: rtl/rcq_window_meter.sv
// Module: rcq_window_meter
// Measures how many local cycles 2^WIN_LOG2 reference periods take. The first
// edge after reset or loss arms the meter; windows then run back to back and
// each ending edge opens the next window. A loss discards the open window.
// Assumes: every period is shorter than LOSS_CYCLES while armed.
module rcq_window_meter #(
    parameter int WIN_LOG2    = 12,
    parameter int LOSS_CYCLES = 4608,
    localparam int CW = $clog2(LOSS_CYCLES) + WIN_LOG2 + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_pulse,
    input  logic          lost,
    output logic          win_done,
    output logic [CW-1:0] win_cycles
);

    logic                armed_q;
    logic [CW-1:0]       acc_q;
    logic [WIN_LOG2-1:0] edges_q;

    // Window accumulation; an arriving edge outranks a stale loss flag (R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            acc_q      <= '0;
            edges_q    <= '0;
            win_done   <= 1'b0;
            win_cycles <= '0;
        end else begin
            win_done <= 1'b0;
            if (rise_pulse) begin
                if (armed_q) begin
                    edges_q <= edges_q + 1'b1;
                    if (&edges_q) begin
                        win_done   <= 1'b1;
                        win_cycles <= acc_q + 1'b1;
                        acc_q      <= '0;
                    end else begin
                        acc_q <= acc_q + 1'b1;
                    end
                end else begin
                    armed_q <= 1'b1;
                    acc_q   <= '0;
                    edges_q <= '0;
                end
            end else if (lost) begin
                armed_q <= 1'b0;
            end else if (armed_q) begin
                acc_q <= acc_q + 1'b1;
            end
        end
    end

    // A window result only appears one cycle after a reference edge.
    p_done_after_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(rise_pulse));

    // A window result never appears right after a loss.
    p_no_done_after_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !rise_pulse) |=> !win_done);

endmodule

// File: rtl/rcq_steer_fsm.sv
// Module: rcq_steer_fsm
// Judges each window against the ppm tolerance, runs the acquire / track /
// holdover / requalify sequence and steers the control word with a
// saturating proportional step.
// Assumes: win_done and lost never coincide (ensured by the meter).
module rcq_steer_fsm
    import rcq_pkg::*;
#(
    parameter int NOM_CYCLES  = 2304,
    parameter int WIN_LOG2    = 12,
    parameter int LOSS_CYCLES = 4608,
    parameter int PPM_LIMIT   = 250,
    parameter int CTRL_W      = 16,
    parameter int GAIN_SHIFT  = 4,
    localparam int CW = $clog2(LOSS_CYCLES) + WIN_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_done,
    input  logic [CW-1:0]     win_cycles,
    input  logic              lost,
    output logic              safe,
    output logic [CTRL_W-1:0] ctrl_word
);

    localparam longint EXP_L = longint'(NOM_CYCLES) << WIN_LOG2;
    localparam longint TOL_L = (EXP_L * longint'(PPM_LIMIT)) / 64'sd1000000;
    localparam logic [CW-1:0]        EXP_V = EXP_L[CW-1:0];
    localparam logic signed [CW:0]   TOL_P = TOL_L[CW:0];
    localparam logic signed [CW:0]   TOL_N = -TOL_P;
    localparam int SW = ((CW > CTRL_W) ? CW : CTRL_W) + 2;
    localparam logic signed [SW-1:0] WMAX = $signed({{(SW-CTRL_W){1'b0}}, {CTRL_W{1'b1}}});
    localparam logic [CTRL_W-1:0]    MID  = {1'b1, {(CTRL_W-1){1'b0}}};

    rcq_state_e          st_q;
    logic                pass_q;
    logic signed [CW:0]  err;
    logic signed [CW:0]  step;
    logic signed [SW-1:0] cand;
    logic [CTRL_W-1:0]   stepped;
    logic                in_range;

    // Window error, tolerance test and the clamped candidate word.
    always_comb begin
        err      = $signed({1'b0, win_cycles}) - $signed({1'b0, EXP_V});
        in_range = (err <= TOL_P) && (err >= TOL_N);
        step     = err >>> GAIN_SHIFT;
        cand     = $signed({{(SW-CTRL_W){1'b0}}, ctrl_word})
                 - $signed({{(SW-CW-1){step[CW]}}, step});
        if (cand < 0) begin
            stepped = '0;
        end else if (cand > WMAX) begin
            stepped = {CTRL_W{1'b1}};
        end else begin
            stepped = cand[CTRL_W-1:0];
        end
    end

    // State sequence and control-word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_ACQUIRE;
            pass_q    <= 1'b0;
            ctrl_word <= MID;
        end else begin
            case (st_q)
                ST_ACQUIRE: begin
                    if (win_done) begin
                        ctrl_word <= stepped;
                        if (in_range) st_q <= ST_TRACK;
                    end
                end
                ST_TRACK: begin
                    if (lost) begin
                        st_q <= ST_HOLDOVER;
                    end else if (win_done) begin
                        if (in_range) ctrl_word <= stepped;
                        else          st_q      <= ST_HOLDOVER;
                    end
                end
                ST_HOLDOVER: begin
                    if (!lost) begin
                        st_q   <= ST_REQUALIFY;
                        pass_q <= 1'b0;
                    end
                end
                ST_REQUALIFY: begin
                    if (lost) begin
                        st_q <= ST_HOLDOVER;
                    end else if (win_done) begin
                        if (!in_range)   pass_q <= 1'b0;
                        else if (pass_q) st_q   <= ST_TRACK;
                        else             pass_q <= 1'b1;
                    end
                end
                default: st_q <= ST_ACQUIRE;
            endcase
        end
    end

    // Status output decoded from the state register.
    always_comb safe = (st_q == ST_TRACK);

    // The word is frozen during holdover and requalification.
    p_word_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLDOVER || st_q == ST_REQUALIFY) |=> $stable(ctrl_word));

    // A reported loss removes the safe status on the next cycle.
    p_safe_drops_on_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !safe);

    // The safe status only rises at the end of a window.
    p_safe_rises_on_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(safe) |-> $past(win_done));

    // An out-of-range window while tracking drops safe and keeps the word.
    p_out_of_range_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK && win_done && !in_range && !lost) |=> (!safe && $stable(ctrl_word)));

endmodule

// File: rtl/ref_clock_qualifier.sv
// Module: ref_clock_qualifier (top)
// Qualifies a slow reference against the local oscillator clock, reports the
// result on safe and steers a frequency-control word that freezes in holdover.
// Assumes: clk is the free-running local oscillator; ref_in is asynchronous.
module ref_clock_qualifier #(
    parameter int NOM_CYCLES  = 2304,
    parameter int LOSS_CYCLES = 4608,
    parameter int WIN_LOG2    = 12,
    parameter int PPM_LIMIT   = 250,
    parameter int CTRL_W      = 16,
    parameter int GAIN_SHIFT  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    output logic              safe,
    output logic [CTRL_W-1:0] ctrl_word
);

    localparam int CW = $clog2(LOSS_CYCLES) + WIN_LOG2 + 1;

    logic          rise_pulse;
    logic          lost;
    logic          win_done;
    logic [CW-1:0] win_cycles;

    rcq_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .rise_pulse (rise_pulse)
    );

    rcq_loss_det #(
        .LOSS_CYCLES (LOSS_CYCLES)
    ) u_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_pulse (rise_pulse),
        .lost       (lost)
    );

    rcq_window_meter #(
        .WIN_LOG2    (WIN_LOG2),
        .LOSS_CYCLES (LOSS_CYCLES)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_pulse (rise_pulse),
        .lost       (lost),
        .win_done   (win_done),
        .win_cycles (win_cycles)
    );

    rcq_steer_fsm #(
        .NOM_CYCLES  (NOM_CYCLES),
        .WIN_LOG2    (WIN_LOG2),
        .LOSS_CYCLES (LOSS_CYCLES),
        .PPM_LIMIT   (PPM_LIMIT),
        .CTRL_W      (CTRL_W),
        .GAIN_SHIFT  (GAIN_SHIFT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_done   (win_done),
        .win_cycles (win_cycles),
        .lost       (lost),
        .safe       (safe),
        .ctrl_word  (ctrl_word)
    );

endmodule

// File: tb/tb_ref_clock_qualifier.sv
// Bench for ref_clock_qualifier with a scaled-down reference: nominal period
// 100 cycles, windows of 4 periods, tolerance 10 cycles per window, 8-bit word.
module tb_ref_clock_qualifier;

    localparam int NOM  = 100;
    localparam int LOSS = 200;
    localparam int WL   = 2;
    localparam int PPM  = 25000;
    localparam int WW   = 8;
    localparam int EXPW = NOM * (2 ** WL);
    localparam int TOL  = (EXPW * PPM) / 1000000;
    localparam int WMAX = (2 ** WW) - 1;
    localparam int MIDW = 2 ** (WW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in = 1'b0;
    logic          safe;
    logic [WW-1:0] ctrl_word;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    pending = 1'b0;
    string ptag = "";
    int    m_st = 0;    // 0 acquire, 1 track, 3 requalify
    int    m_word = MIDW;
    int    m_pass = 0;

    always #2.5 clk = ~clk;

    ref_clock_qualifier #(
        .NOM_CYCLES  (NOM),
        .LOSS_CYCLES (LOSS),
        .WIN_LOG2    (WL),
        .PPM_LIMIT   (PPM),
        .CTRL_W      (WW),
        .GAIN_SHIFT  (0),
        .SYNC_STAGES (2)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .safe      (safe),
        .ctrl_word (ctrl_word)
    );

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_out(string tag);
        int es;
        es = (m_st == 1) ? 1 : 0;
        check(int'(safe) == es, {tag, " safe"}, int'(safe), es);
        check(int'(ctrl_word) == m_word, {tag, " word"}, int'(ctrl_word), m_word);
    endtask

    function automatic int clampw(int v);
        if (v < 0) return 0;
        if (v > WMAX) return WMAX;
        return v;
    endfunction

    // Expected effect of one completed window (R2..R5, R7, R8).
    task automatic model_win(int err);
        bit inr;
        inr = (err >= -TOL) && (err <= TOL);
        case (m_st)
            0: begin
                m_word = clampw(m_word - err);
                if (inr) m_st = 1;
            end
            1: begin
                if (inr) m_word = clampw(m_word - err);
                else begin m_st = 3; m_pass = 0; end
            end
            default: begin
                if (!inr) m_pass = 0;
                else if (m_pass == 1) m_st = 1;
                else m_pass = 1;
            end
        endcase
    endtask

    // One reference period: rising edge, optional pending check, low tail.
    task automatic drive_period(int p, int hi);
        @(negedge clk) ref_in = 1'b1;
        repeat (9) @(negedge clk);
        if (pending) begin
            check_out(ptag);
            pending = 1'b0;
        end
        repeat (hi - 10) @(negedge clk);
        ref_in = 1'b0;
        repeat (p - hi) @(negedge clk);
    endtask

    // Four periods with random high time (R9); checked at the next edge.
    task automatic win4(int p0, int p1, int p2, int p3, string tag);
        drive_period(p0, $urandom_range(p0 - 5, 10));
        drive_period(p1, $urandom_range(p1 - 5, 10));
        drive_period(p2, $urandom_range(p2 - 5, 10));
        drive_period(p3, $urandom_range(p3 - 5, 10));
        model_win(p0 + p1 + p2 + p3 - EXPW);
        ptag = tag;
        pending = 1'b1;
    endtask

    task automatic close_edge();
        drive_period(NOM, NOM / 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_in = 1'b0;
        pending = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0;
        m_word = MIDW;
        m_pass = 0;
        @(negedge clk);
        check_out("R1 reset state");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        win4(100, 100, 100, 103, "R3 acquire lock");
        for (int i = 0; i < 6; i++) begin
            win4($urandom_range(102, 98), $urandom_range(102, 98),
                 $urandom_range(102, 98), $urandom_range(102, 98), "R4 random track");
        end
        win4(100, 100, 100, 110, "R2 upper tolerance in range");
        win4(100, 100, 100, 90,  "R2 lower tolerance in range");
        win4(100, 100, 100, 111, "R5 out of range to holdover");
        win4(100, 100, 100, 100, "R7 requalify first pass");
        win4(100, 100, 100, 89,  "R7 out of range restarts count");
        win4(100, 100, 100, 100, "R7 requalify first pass again");
        win4(100, 100, 100, 102, "R7 requalify second pass");
        win4(100, 100, 100, 98,  "R4 tracking resumes");
        close_edge();

        // Loss: hold the reference low well past the loss limit (R6).
        repeat (250) @(negedge clk);
        if (m_st != 0) begin m_st = 3; m_pass = 0; end
        check_out("R6 loss holdover");

        // Arming edge coincides with the loss flag (R10).
        win4(100, 100, 100, 100, "R10 first window after loss");
        win4(100, 100, 100, 100, "R10 R7 second window after loss");
        win4(100, 100, 100, 105, "R10 R4 exact step after loss");
        close_edge();

        // Upper clamp: slow local count keeps raising the word in acquire.
        do_reset();
        for (int i = 0; i < 12; i++) win4(97, 97, 97, 97, "R8 upper clamp");
        close_edge();

        // Lower clamp: fast local count keeps lowering the word.
        do_reset();
        for (int i = 0; i < 12; i++) win4(103, 103, 103, 103, "R8 lower clamp");
        close_edge();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule